// File: doc/BRIEF.md
# Dual-Mode Programmable Swallow Divider

This block divides a local-oscillator clock by a programmable ratio. It emits a pulse one input clock wide each time a full division completes, and a phase detector that compares the divided signal with a reference consumes that pulse. The divide word is split into two fields: an 8-bit main field and a 6-bit swallow field.

In swallow mode, a synchronous model of a dual-modulus prescaler counts out prescaler cycles. The main field sets how many prescaler cycles there are. The swallow field sets how many of them run one clock longer. A band input selects the modulus pair: 64/65 or 32/33. In direct mode, the two fields join into a single 14-bit ratio, which suits the lower bands.

New divide settings take effect only when a division completes, so a division that has already started is never shortened. The standby input stops the divider and holds the output quiet. When standby is released, division starts again from the beginning.

Top module: `swallow_divider`

## Requirements
- R1: With `swallowMode`=1 and `halfModulus`=0, the pulse period is 64*M + S input clocks. M is `mainWord` and S is `swallowWord`. The first S prescaler cycles last 65 clocks and the rest last 64.
- R2: With `swallowMode`=1 and `halfModulus`=1, the period is 32*M + S clocks. The prescaler cycles last 33 and 32 clocks.
- R3: In swallow mode, if M <= S the divider uses M = S + 1. For example, M=2, S=5 on the 64/65 pair gives 389 clocks.
- R4: With `swallowMode`=0, the period is the 14-bit value {mainWord, swallowWord}, with `mainWord` as the upper bits. `halfModulus` has no effect in this mode. A value below 2 gives a period of 2.
- R5: `divPulse` is high for exactly one clock per division, and consecutive pulses are exactly one period apart.
- R6: Divide words and mode inputs are sampled only on the edge where a division completes, or on the first edge after a restart. A change made during a division does not alter that division or the one that begins on the next terminal edge when the change arrives after it.
- R7: While `standby` is high, `divPulse` stays low. After release, the first pulse rises on the Nth rising edge after the first edge that has both `standby` and `rst` low. N is the period.
- R8: While `rst` (synchronous, active high) is high, `divPulse` is low. After release, the first pulse follows the same timing as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-oscillator input clock |
| rst | input | 1 | Synchronous reset, active high |
| standby | input | 1 | Stops division and silences the output |
| swallowMode | input | 1 | 1 = prescaler/swallow mode, 0 = direct 14-bit mode |
| halfModulus | input | 1 | Swallow mode only: 1 = 32/33 pair, 0 = 64/65 pair |
| mainWord | input | 8 | Main count (upper field in direct mode) |
| swallowWord | input | 6 | Swallow count (lower field in direct mode) |
| divPulse | output | 1 | One-clock pulse at each completed division |

## Verification
A wrong segment length, or a swallow count that runs off by one, shows up at the output as a pulse spacing that misses the expected ratio by a small amount. It is visible at the second pulse, at most two periods after a restart. A terminal edge that loads the wrong value reveals itself one period later, when the next spacing is measured. A counter that fails to reload stops the pulses completely, and the bound on the gap between pulses catches this within one maximum period.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic segLoad;  // start a new segment this edge
    logic fire;     // division complete: pulse next cycle
    logic clear;    // standby: hold everything idle
  } segStrobe_t;
endpackage

// File: rtl/swdiv_datapath.sv
module swdiv_datapath
  import swdiv_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  segStrobe_t       strb,
  input  logic [LEN_W-1:0] segLen,
  output logic             segEnd,
  output logic             divPulse
);
  logic [LEN_W-1:0] segCnt;

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      segCnt   <= '0;
      divPulse <= 1'b0;
    end else begin
      divPulse <= strb.fire;
      if (strb.segLoad)
        segCnt <= segLen;
      else if (segCnt != '0)
        segCnt <= segCnt - 1'b1;
    end
  end

  assign segEnd = (segCnt == '0);
endmodule

// File: rtl/swdiv_control.sv
module swdiv_control
  import swdiv_pkg::*;
#(
  parameter int MAIN_W  = 8,
  parameter int SWAL_W  = 6,
  parameter int PRE_LOG = 6,
  localparam int LEN_W  = MAIN_W + SWAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              swallowMode,
  input  logic              halfModulus,
  input  logic [MAIN_W-1:0] mainWord,
  input  logic [SWAL_W-1:0] swallowWord,
  input  logic              segEnd,
  output segStrobe_t        strb,
  output logic [LEN_W-1:0]  segLen
);
  localparam int BIG_MOD   = 1 << PRE_LOG;
  localparam int SMALL_MOD = 1 << (PRE_LOG - 1);

  logic              primed;
  logic              curHalf;
  logic [MAIN_W-1:0] segRem;
  logic [SWAL_W-1:0] swRem;

  logic [MAIN_W-1:0] swExt, mainEff;
  logic [LEN_W-1:0]  baseNew, baseCur, firstLen, nextLen, directLen, directLoad;
  logic              terminal, nextSeg, startPeriod;

  always_comb begin
    swExt      = MAIN_W'(swallowWord);
    mainEff    = (mainWord <= swExt) ? swExt + 1'b1 : mainWord;
    baseNew    = halfModulus ? LEN_W'(SMALL_MOD) : LEN_W'(BIG_MOD);
    baseCur    = curHalf     ? LEN_W'(SMALL_MOD) : LEN_W'(BIG_MOD);
    firstLen   = baseNew + LEN_W'(swallowWord != '0) - LEN_W'(1);
    nextLen    = baseCur + LEN_W'(swRem != '0) - LEN_W'(1);
    directLen  = {mainWord, swallowWord};
    directLoad = (directLen < LEN_W'(2)) ? LEN_W'(1) : directLen - LEN_W'(1);

    terminal    = primed && segEnd && (segRem == '0);
    nextSeg     = primed && segEnd && (segRem != '0);
    startPeriod = !primed || terminal;

    if (startPeriod) segLen = swallowMode ? firstLen : directLoad;
    else             segLen = nextLen;

    strb.clear   = standby;
    strb.segLoad = !standby && (startPeriod || nextSeg);
    strb.fire    = !standby && terminal;
  end

  always_ff @(posedge clk) begin
    if (rst || standby) begin
      primed  <= 1'b0;
      curHalf <= 1'b0;
      segRem  <= '0;
      swRem   <= '0;
    end else if (startPeriod) begin
      primed  <= 1'b1;
      curHalf <= halfModulus;
      if (swallowMode) begin
        segRem <= mainEff - 1'b1;
        swRem  <= swallowWord - SWAL_W'(swallowWord != '0);
      end else begin
        segRem <= '0;
        swRem  <= '0;
      end
    end else if (nextSeg) begin
      segRem <= segRem - 1'b1;
      if (swRem != '0) swRem <= swRem - 1'b1;
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int MAIN_W  = 8,
  parameter int SWAL_W  = 6,
  parameter int PRE_LOG = 6,
  localparam int LEN_W  = MAIN_W + SWAL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              swallowMode,
  input  logic              halfModulus,
  input  logic [MAIN_W-1:0] mainWord,
  input  logic [SWAL_W-1:0] swallowWord,
  output logic              divPulse
);
  segStrobe_t       strb;
  logic [LEN_W-1:0] segLen;
  logic             segEnd;

  swdiv_control #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .PRE_LOG(PRE_LOG)) ctrl (
    .clk(clk), .rst(rst), .standby(standby), .swallowMode(swallowMode),
    .halfModulus(halfModulus), .mainWord(mainWord), .swallowWord(swallowWord),
    .segEnd(segEnd), .strb(strb), .segLen(segLen)
  );

  swdiv_datapath #(.LEN_W(LEN_W)) dp (
    .clk(clk), .rst(rst), .strb(strb), .segLen(segLen),
    .segEnd(segEnd), .divPulse(divPulse)
  );
endmodule

// File: rtl/swdiv_checker.sv
module swdiv_checker #(
  parameter int LEN_W = 14
) (
  input logic clk,
  input logic rst,
  input logic standby,
  input logic divPulse,
  input logic segEnd,
  input logic segLoad,
  input logic fire
);
  localparam int GAP_W   = LEN_W + 1;
  localparam int GAP_MAX = (1 << LEN_W) + 4;

  logic [GAP_W-1:0] gapCnt;

  always_ff @(posedge clk) begin
    if (rst || standby || divPulse) gapCnt <= '0;
    else if (gapCnt != GAP_W'(GAP_MAX)) gapCnt <= gapCnt + 1'b1;
  end

  AST_ONE_CYCLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    divPulse |=> !divPulse); // R5
  AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (rst)
    standby |=> !divPulse); // R7
  AST_SEG_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (!standby && segEnd) |-> segLoad); // R5
  AST_PULSE_FROM_FIRE: assert property (@(posedge clk) disable iff (rst)
    $rose(divPulse) |-> $past(fire)); // R5
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    gapCnt < GAP_W'(GAP_MAX)); // R5
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
    divPulse |-> gapCnt >= GAP_W'(1)); // R4
endmodule

bind swallow_divider swdiv_checker #(.LEN_W(LEN_W)) chk (
  .clk(clk), .rst(rst), .standby(standby), .divPulse(divPulse),
  .segEnd(segEnd), .segLoad(strb.segLoad), .fire(strb.fire)
);

// File: tb/tb_swallow_divider.sv
module tb_swallow_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       standby = 1'b0;
  logic       swallowMode = 1'b1;
  logic       halfModulus = 1'b0;
  logic [7:0] mainWord = '0;
  logic [5:0] swallowWord = '0;
  logic       divPulse;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  swallow_divider dut (
    .clk(clk), .rst(rst), .standby(standby), .swallowMode(swallowMode),
    .halfModulus(halfModulus), .mainWord(mainWord), .swallowWord(swallowWord),
    .divPulse(divPulse)
  );

  typedef struct packed {
    logic        sw;
    logic        half;
    logic [7:0]  pc;
    logic [5:0]  sc;
    logic [15:0] expN;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'd3,  6'd2,  16'd194, 8'd1}, // R1
    '{1'b1, 1'b0, 8'd10, 6'd0,  16'd640, 8'd1}, // R1
    '{1'b1, 1'b1, 8'd4,  6'd3,  16'd131, 8'd2}, // R2
    '{1'b1, 1'b1, 8'd0,  6'd0,  16'd32,  8'd3}, // R3 on 32/33 pair
    '{1'b1, 1'b0, 8'd2,  6'd5,  16'd389, 8'd3}, // R3
    '{1'b1, 1'b0, 8'd4,  6'd4,  16'd324, 8'd3}, // R3
    '{1'b0, 1'b0, 8'd0,  6'd37, 16'd37,  8'd4}, // R4
    '{1'b0, 1'b0, 8'd1,  6'd3,  16'd67,  8'd4}, // R4
    '{1'b0, 1'b0, 8'd0,  6'd0,  16'd2,   8'd4}, // R4 clamp
    '{1'b0, 1'b1, 8'd2,  6'd0,  16'd128, 8'd4}  // R4 band ignored
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setCfg(input logic sw, input logic half, input logic [7:0] pc, input logic [5:0] sc);
    swallowMode = sw; halfModulus = half; mainWord = pc; swallowWord = sc;
  endtask

  task automatic restart();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // negedges from now until the pulse is seen high
  task automatic waitPulse(output int n);
    n = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      n++;
      if (divPulse) break;
    end
  endtask

  // called while pulse seen high: returns width and spacing to the next pulse
  task automatic measurePeriod(output int per, output int width);
    width = 1; per = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      per++;
      if (!divPulse) break;
      width++;
    end
    for (int i = 0; i < 20000; i++) begin
      if (divPulse) break;
      @(negedge clk);
      per++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, per, width, cnt;
    // R8: output low while reset held
    cnt = 0;
    repeat (5) begin @(negedge clk); if (divPulse) cnt++; end
    check(cnt == 0, "R8 pulse during reset", cnt, 0);

    for (int v = 0; v < NV; v++) begin
      setCfg(VECS[v].sw, VECS[v].half, VECS[v].pc, VECS[v].sc);
      restart();
      waitPulse(n);
      check(n == int'(VECS[v].expN) + 1, $sformatf("R%0d first pulse (R8)", VECS[v].req),
            n, int'(VECS[v].expN) + 1);
      measurePeriod(per, width);
      check(per == int'(VECS[v].expN), $sformatf("R%0d period vec %0d", VECS[v].req, v),
            per, int'(VECS[v].expN));
      check(width == 1, "R5 pulse width", width, 1);
    end

    // R7: standby silences output and restarts division
    setCfg(1'b1, 1'b0, 8'd3, 6'd2);
    restart();
    @(negedge clk); standby = 1'b1;
    cnt = 0;
    repeat (600) begin @(negedge clk); if (divPulse) cnt++; end
    check(cnt == 0, "R7 pulses in standby", cnt, 0);
    standby = 1'b0;
    waitPulse(n);
    check(n == 195, "R7 first pulse after standby", n, 195);

    // R7: standby mid-division cuts it and restarts cleanly
    repeat (50) @(negedge clk);
    standby = 1'b1;
    repeat (3) @(negedge clk);
    standby = 1'b0;
    waitPulse(n);
    check(n == 195, "R7 restart after mid-division standby", n, 195);

    // R6: change during a division takes effect one division later
    setCfg(1'b1, 1'b0, 8'd3, 6'd2);
    restart();
    waitPulse(n);
    repeat (5) @(negedge clk);
    setCfg(1'b1, 1'b0, 8'd2, 6'd0);
    waitPulse(n);
    check(n == 189, "R6 division in progress kept", n + 5, 194);
    measurePeriod(per, width);
    check(per == 128, "R6 new ratio applied", per, 128);

    // R6: mode switch to direct during a division
    repeat (7) @(negedge clk);
    setCfg(1'b0, 1'b0, 8'd0, 6'd50);
    waitPulse(n);
    check(n == 121, "R6 mode change deferred", n + 7, 128);
    measurePeriod(per, width);
    check(per == 50, "R6 direct ratio after switch", per, 50);
    measurePeriod(per, width);
    check(per == 50, "R5 steady spacing", per, 50);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule